// File: doc/BRIEF.md
# Lane-Degradable Flit Serializer and Deserializer

This block moves 80-bit link units (flits) across a lane bus of twenty data lanes arranged as four five-lane quadrants. The transmit half takes one flit at a time through a valid/ready handshake. It cuts the flit into beats, least-significant bits first, and drives one beat per clock on the lanes. The receive half collects beats from the lanes and presents the rebuilt flit as a one-cycle pulse. It marks a framing error when the beat stream breaks.

Each half has its own width and quadrant-enable inputs. At full width all four quadrants carry a 20-bit beat and a flit takes 4 beats. At half width the first two enabled quadrants in ascending order carry a 10-bit beat, for 8 beats. At quarter width the lowest enabled quadrant carries a 5-bit beat, for 16 beats. The transmitter samples its configuration when it accepts a flit, and the receiver samples its configuration on the start-of-flit beat. A configuration change in the middle of a flit therefore takes effect at the next flit boundary.

Back-pressure rules: `tx_ready` is high when no flit is in flight, and during the last beat of the flit in flight. A flit transfers on a rising edge where `tx_valid` and `tx_ready` are both high, so flits can follow one another with no idle beat. While `tx_ready` is low the source holds `tx_valid` and `tx_flit`. The receive side has no back-pressure: every beat presented is consumed.

Top module: `flit_lane_serdes`

## Requirements
- R1: A flit is accepted on an edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high when no flit is in flight, and during the last beat of one. The first beat appears in the cycle after acceptance, with `tx_sof` high.
- R2: Width code 2'b00 (full) sends 4 beats. Beat b carries flit bits [20b+19:20b], and flit bit 20b+i is on lane i. The quadrant mask is ignored.
- R3: Width code 2'b01 (half) sends 8 beats of 10 bits. Beat bits [4:0] go on the lowest enabled quadrant and bits [9:5] on the next enabled quadrant. Quadrant q occupies lanes [5q+4:5q], and mask bit q enables it.
- R4: Width code 2'b10 (quarter, and 2'b11 treated alike) sends 16 beats of 5 bits on the lowest enabled quadrant.
- R5: Lanes outside the quadrants in use, and all lanes when no beat is valid, are zero.
- R6: Width and mask are sampled when a flit is accepted. A change while the flit is in flight does not alter its beats.
- R7: Within a flit, beats are sent on consecutive cycles. A flit accepted on the last beat of the previous one starts on the next cycle.
- R8: When the last beat of a flit is received, `rx_flit_valid` is high for exactly the following cycle, with the rebuilt flit on `rx_flit`.
- R9: The receiver takes its width and mask from `rx_cfg_width`/`rx_cfg_quad_en` on the `rx_sof` beat, and unpacks lanes with the same mapping as R2 to R4.
- R10: A beat with `rx_sof` high while a flit is partly received, or a beat with `rx_sof` low while none is, sets `rx_frame_err`. While `rx_frame_err` is set, beats are ignored and no flit is presented. A cycle with `rx_frame_reset` high clears the error and any partial flit. If `rx_sof` comes in that same cycle, it starts a new flit.
- R11: After reset, `tx_ready` is 1, and `tx_beat_valid`, `tx_lanes`, `rx_flit_valid` and `rx_frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 2 | Transmit width code |
| cfg_quad_en | input | 4 | Transmit quadrant enable mask |
| tx_valid | input | 1 | Flit offered |
| tx_ready | output | 1 | Flit can be accepted |
| tx_flit | input | 80 | Flit to send |
| tx_lanes | output | 20 | Transmit lane bus |
| tx_beat_valid | output | 1 | A beat is on the lanes |
| tx_sof | output | 1 | Current beat is the first of a flit |
| rx_cfg_width | input | 2 | Receive width code |
| rx_cfg_quad_en | input | 4 | Receive quadrant enable mask |
| rx_lanes | input | 20 | Receive lane bus |
| rx_beat_valid | input | 1 | A beat is on the receive lanes |
| rx_sof | input | 1 | Receive beat is the first of a flit |
| rx_frame_reset | input | 1 | Clears framing error and partial flit |
| rx_flit_valid | output | 1 | Rebuilt flit pulse |
| rx_flit | output | 80 | Rebuilt flit |
| rx_frame_err | output | 1 | Framing error held |

## Verification
Two pairs of events can land in the same cycle. On transmit, the last beat of one flit and the acceptance of the next share a cycle. On receive, `rx_frame_reset` and a start-of-flit beat share a cycle. The first pair comes up on every back-to-back pair of flits in a sweep over all widths and all usable quadrant masks, with transmit looped to receive. Every beat is compared with lane values computed from the flit, and every rebuilt flit is compared with the one sent. The second pair is set up deliberately after a dropped beat. That flit must then arrive intact, with the error cleared, and no flit may surface while the error is held.

// File: rtl/flit_serdes_pkg.sv
package flit_serdes_pkg;

  typedef enum logic [1:0] {
    WID_FULL    = 2'b00,
    WID_HALF    = 2'b01,
    WID_QUARTER = 2'b10,
    WID_RSVD    = 2'b11
  } link_width_e;

  // Number of quadrants that carry data for a width code.
  function automatic int unsigned quads_in_use(input logic [1:0] w, input int unsigned nq);
    case (w)
      WID_FULL: return nq;
      WID_HALF: return nq / 2;
      default:  return nq / 4;
    endcase
  endfunction

endpackage

// File: rtl/flit_lane_mapper.sv
module flit_lane_mapper
  import flit_serdes_pkg::*;
#(
  parameter int QUAD_LANES = 5,
  parameter int NUM_QUADS  = 4
) (
  input  logic [NUM_QUADS*QUAD_LANES-1:0] slice_i,
  input  logic [1:0]                      width_i,
  input  logic [NUM_QUADS-1:0]            mask_i,
  output logic [NUM_QUADS*QUAD_LANES-1:0] lanes_o
);

  always_comb begin
    int unsigned n_use;
    int unsigned rank;
    logic [NUM_QUADS-1:0] live;
    n_use   = quads_in_use(width_i, NUM_QUADS);
    live    = (width_i == WID_FULL) ? {NUM_QUADS{1'b1}} : mask_i;
    rank    = 0;
    lanes_o = '0;
    for (int q = 0; q < NUM_QUADS; q++) begin
      if (live[q] && (rank < n_use)) begin
        lanes_o[q*QUAD_LANES +: QUAD_LANES] = slice_i[rank*QUAD_LANES +: QUAD_LANES];
        rank = rank + 1;
      end
    end
  end

endmodule

// File: rtl/flit_lane_unmapper.sv
module flit_lane_unmapper
  import flit_serdes_pkg::*;
#(
  parameter int QUAD_LANES = 5,
  parameter int NUM_QUADS  = 4
) (
  input  logic [NUM_QUADS*QUAD_LANES-1:0] lanes_i,
  input  logic [1:0]                      width_i,
  input  logic [NUM_QUADS-1:0]            mask_i,
  output logic [NUM_QUADS*QUAD_LANES-1:0] slice_o
);

  always_comb begin
    int unsigned n_use;
    int unsigned rank;
    logic [NUM_QUADS-1:0] live;
    n_use   = quads_in_use(width_i, NUM_QUADS);
    live    = (width_i == WID_FULL) ? {NUM_QUADS{1'b1}} : mask_i;
    rank    = 0;
    slice_o = '0;
    for (int q = 0; q < NUM_QUADS; q++) begin
      if (live[q] && (rank < n_use)) begin
        slice_o[rank*QUAD_LANES +: QUAD_LANES] = lanes_i[q*QUAD_LANES +: QUAD_LANES];
        rank = rank + 1;
      end
    end
  end

endmodule

// File: rtl/flit_tx_serializer.sv
module flit_tx_serializer
  import flit_serdes_pkg::*;
#(
  parameter int FLIT_W     = 80,
  parameter int QUAD_LANES = 5,
  parameter int NUM_QUADS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [FLIT_W-1:0]               in_flit,
  input  logic [1:0]                      cfg_width_i,
  input  logic [NUM_QUADS-1:0]            cfg_mask_i,
  output logic [NUM_QUADS*QUAD_LANES-1:0] slice_o,
  output logic [1:0]                      cur_width_o,
  output logic [NUM_QUADS-1:0]            cur_mask_o,
  output logic                            beat_valid_o,
  output logic                            sof_o
);

  localparam int LANES      = NUM_QUADS * QUAD_LANES;
  localparam int MAX_BEATS  = FLIT_W / QUAD_LANES;
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);
  localparam int STEP_W     = $clog2(LANES + 1);
  localparam int BITS_FULL  = LANES;
  localparam int BITS_HALF  = LANES / 2;
  localparam int BITS_QTR   = LANES / 4;

  logic                 busy_q;
  logic [CNT_W-1:0]     beat_q;
  logic [FLIT_W-1:0]    shift_q;
  logic [1:0]           width_q;
  logic [NUM_QUADS-1:0] mask_q;

  logic [STEP_W-1:0]    step_bits;
  logic [CNT_W-1:0]     last_idx;
  logic                 last_beat;
  logic                 take;

  always_comb begin
    case (width_q)
      WID_FULL: begin step_bits = STEP_W'(BITS_FULL); last_idx = CNT_W'(FLIT_W / BITS_FULL - 1); end
      WID_HALF: begin step_bits = STEP_W'(BITS_HALF); last_idx = CNT_W'(FLIT_W / BITS_HALF - 1); end
      default:  begin step_bits = STEP_W'(BITS_QTR);  last_idx = CNT_W'(FLIT_W / BITS_QTR - 1);  end
    endcase
  end

  assign last_beat = busy_q && (beat_q == last_idx);
  assign in_ready  = !busy_q || last_beat;
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      shift_q <= '0;
      width_q <= WID_FULL;
      mask_q  <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      beat_q  <= '0;
      shift_q <= in_flit;
      width_q <= cfg_width_i;
      mask_q  <= cfg_mask_i;
    end else if (busy_q) begin
      shift_q <= shift_q >> step_bits;
      beat_q  <= beat_q + 1'b1;
      if (last_beat) busy_q <= 1'b0;
    end
  end

  assign slice_o      = busy_q ? shift_q[LANES-1:0] : '0;
  assign beat_valid_o = busy_q;
  assign sof_o        = busy_q && (beat_q == '0);
  assign cur_width_o  = width_q;
  assign cur_mask_o   = mask_q;

endmodule

// File: rtl/flit_rx_deserializer.sv
module flit_rx_deserializer
  import flit_serdes_pkg::*;
#(
  parameter int FLIT_W     = 80,
  parameter int QUAD_LANES = 5,
  parameter int NUM_QUADS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            beat_valid_i,
  input  logic                            sof_i,
  input  logic                            frame_reset_i,
  input  logic [1:0]                      cfg_width_i,
  input  logic [NUM_QUADS-1:0]            cfg_mask_i,
  input  logic [NUM_QUADS*QUAD_LANES-1:0] slice_i,
  output logic [1:0]                      sel_width_o,
  output logic [NUM_QUADS-1:0]            sel_mask_o,
  output logic                            flit_valid_o,
  output logic [FLIT_W-1:0]               flit_o,
  output logic                            frame_err_o
);

  localparam int LANES      = NUM_QUADS * QUAD_LANES;
  localparam int MAX_BEATS  = FLIT_W / QUAD_LANES;
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);
  localparam int POS_W      = $clog2(FLIT_W + 1);
  localparam int BITS_FULL  = LANES;
  localparam int BITS_HALF  = LANES / 2;
  localparam int BITS_QTR   = LANES / 4;

  logic                 busy_q;
  logic                 err_q;
  logic                 fv_q;
  logic [CNT_W-1:0]     beat_q;
  logic [FLIT_W-1:0]    acc_q;
  logic [FLIT_W-1:0]    flit_q;
  logic [1:0]           width_q;
  logic [NUM_QUADS-1:0] mask_q;

  logic                 live_busy;
  logic                 blocked;
  logic                 starting;
  logic [POS_W-1:0]     step_bits;
  logic [POS_W-1:0]     top_pos;
  logic [CNT_W-1:0]     last_idx;
  logic [FLIT_W-1:0]    widened;
  logic [FLIT_W-1:0]    merged;

  assign live_busy = busy_q && !frame_reset_i;
  assign blocked   = err_q && !frame_reset_i;
  assign starting  = beat_valid_i && sof_i && !live_busy && !blocked;

  assign sel_width_o = starting ? cfg_width_i : width_q;
  assign sel_mask_o  = starting ? cfg_mask_i  : mask_q;

  always_comb begin
    case (sel_width_o)
      WID_FULL: begin step_bits = POS_W'(BITS_FULL); last_idx = CNT_W'(FLIT_W / BITS_FULL - 1); end
      WID_HALF: begin step_bits = POS_W'(BITS_HALF); last_idx = CNT_W'(FLIT_W / BITS_HALF - 1); end
      default:  begin step_bits = POS_W'(BITS_QTR);  last_idx = CNT_W'(FLIT_W / BITS_QTR - 1);  end
    endcase
  end

  // New beat enters at the top; earlier beats move toward bit 0.
  assign top_pos = POS_W'(FLIT_W) - step_bits;
  assign widened = {{(FLIT_W-LANES){1'b0}}, slice_i} << top_pos;
  assign merged  = starting ? widened : ((acc_q >> step_bits) | widened);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      fv_q    <= 1'b0;
      beat_q  <= '0;
      acc_q   <= '0;
      flit_q  <= '0;
      width_q <= WID_FULL;
      mask_q  <= '0;
    end else begin
      fv_q <= 1'b0;
      if (frame_reset_i) begin
        err_q  <= 1'b0;
        busy_q <= 1'b0;
      end
      if (beat_valid_i && !blocked) begin
        if (sof_i) begin
          if (live_busy) begin
            err_q  <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            busy_q  <= 1'b1;
            beat_q  <= CNT_W'(1);
            acc_q   <= merged;
            width_q <= cfg_width_i;
            mask_q  <= cfg_mask_i;
          end
        end else if (!live_busy) begin
          err_q <= 1'b1;
        end else begin
          acc_q  <= merged;
          beat_q <= beat_q + 1'b1;
          if (beat_q == last_idx) begin
            busy_q <= 1'b0;
            fv_q   <= 1'b1;
            flit_q <= merged;
          end
        end
      end
    end
  end

  assign flit_valid_o = fv_q;
  assign flit_o       = flit_q;
  assign frame_err_o  = err_q;

endmodule

// File: rtl/flit_lane_serdes.sv
module flit_lane_serdes
  import flit_serdes_pkg::*;
#(
  parameter int FLIT_W     = 80,
  parameter int QUAD_LANES = 5,
  parameter int NUM_QUADS  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      cfg_width,
  input  logic [NUM_QUADS-1:0]            cfg_quad_en,
  input  logic                            tx_valid,
  output logic                            tx_ready,
  input  logic [FLIT_W-1:0]               tx_flit,
  output logic [NUM_QUADS*QUAD_LANES-1:0] tx_lanes,
  output logic                            tx_beat_valid,
  output logic                            tx_sof,
  input  logic [1:0]                      rx_cfg_width,
  input  logic [NUM_QUADS-1:0]            rx_cfg_quad_en,
  input  logic [NUM_QUADS*QUAD_LANES-1:0] rx_lanes,
  input  logic                            rx_beat_valid,
  input  logic                            rx_sof,
  input  logic                            rx_frame_reset,
  output logic                            rx_flit_valid,
  output logic [FLIT_W-1:0]               rx_flit,
  output logic                            rx_frame_err
);

  localparam int LANES = NUM_QUADS * QUAD_LANES;

  logic [LANES-1:0]     tx_slice;
  logic [1:0]           tx_cur_width;
  logic [NUM_QUADS-1:0] tx_cur_mask;
  logic [LANES-1:0]     rx_slice;
  logic [1:0]           rx_sel_width;
  logic [NUM_QUADS-1:0] rx_sel_mask;

  flit_tx_serializer #(.FLIT_W(FLIT_W), .QUAD_LANES(QUAD_LANES), .NUM_QUADS(NUM_QUADS)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (tx_valid),
    .in_ready     (tx_ready),
    .in_flit      (tx_flit),
    .cfg_width_i  (cfg_width),
    .cfg_mask_i   (cfg_quad_en),
    .slice_o      (tx_slice),
    .cur_width_o  (tx_cur_width),
    .cur_mask_o   (tx_cur_mask),
    .beat_valid_o (tx_beat_valid),
    .sof_o        (tx_sof)
  );

  flit_lane_mapper #(.QUAD_LANES(QUAD_LANES), .NUM_QUADS(NUM_QUADS)) u_map (
    .slice_i (tx_slice),
    .width_i (tx_cur_width),
    .mask_i  (tx_cur_mask),
    .lanes_o (tx_lanes)
  );

  flit_lane_unmapper #(.QUAD_LANES(QUAD_LANES), .NUM_QUADS(NUM_QUADS)) u_unmap (
    .lanes_i (rx_lanes),
    .width_i (rx_sel_width),
    .mask_i  (rx_sel_mask),
    .slice_o (rx_slice)
  );

  flit_rx_deserializer #(.FLIT_W(FLIT_W), .QUAD_LANES(QUAD_LANES), .NUM_QUADS(NUM_QUADS)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .beat_valid_i  (rx_beat_valid),
    .sof_i         (rx_sof),
    .frame_reset_i (rx_frame_reset),
    .cfg_width_i   (rx_cfg_width),
    .cfg_mask_i    (rx_cfg_quad_en),
    .slice_i       (rx_slice),
    .sel_width_o   (rx_sel_width),
    .sel_mask_o    (rx_sel_mask),
    .flit_valid_o  (rx_flit_valid),
    .flit_o        (rx_flit),
    .frame_err_o   (rx_frame_err)
  );

endmodule

// File: rtl/flit_lane_serdes_chk.sv
module flit_lane_serdes_chk #(
  parameter int LANES = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_beat_valid,
  input logic             tx_sof,
  input logic [LANES-1:0] tx_lanes,
  input logic             rx_beat_valid,
  input logic             rx_frame_reset,
  input logic             rx_flit_valid,
  input logic             rx_frame_err
);

  assert_accept_starts_flit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> tx_beat_valid && tx_sof);

  assert_sof_is_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof |-> tx_beat_valid);

  assert_idle_lanes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_beat_valid |-> tx_lanes == '0);

  assert_no_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_beat_valid && !tx_ready |=> tx_beat_valid && !tx_sof);

  assert_flit_follows_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flit_valid |-> $past(rx_beat_valid));

  assert_flit_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flit_valid |=> !rx_flit_valid);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err && !rx_frame_reset |=> rx_frame_err);

  assert_err_blocks_flit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> !rx_flit_valid);

endmodule

bind flit_lane_serdes flit_lane_serdes_chk #(.LANES(NUM_QUADS*QUAD_LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .tx_beat_valid  (tx_beat_valid),
  .tx_sof         (tx_sof),
  .tx_lanes       (tx_lanes),
  .rx_beat_valid  (rx_beat_valid),
  .rx_frame_reset (rx_frame_reset),
  .rx_flit_valid  (rx_flit_valid),
  .rx_frame_err   (rx_frame_err)
);

// File: tb/flit_lane_serdes_bench.sv
module flit_lane_serdes_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 80;
  localparam int NQ = 4;
  localparam int QL = 5;
  localparam int LN = NQ * QL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]    cfg_width = 2'b00;
  logic [NQ-1:0] cfg_quad_en = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [FW-1:0] tx_flit = '0;
  logic [LN-1:0] tx_lanes;
  logic          tx_beat_valid, tx_sof;
  logic [1:0]    rx_cfg_width = 2'b00;
  logic [NQ-1:0] rx_cfg_quad_en = '0;
  logic          rx_flit_valid, rx_frame_err;
  logic [FW-1:0] rx_flit;

  logic          loop_en = 1'b1;
  logic [LN-1:0] d_lanes = '0;
  logic          d_valid = 1'b0, d_sof = 1'b0, d_freset = 1'b0;

  logic [LN-1:0] rx_lanes;
  logic          rx_beat_valid, rx_sof;
  assign rx_lanes      = loop_en ? tx_lanes      : d_lanes;
  assign rx_beat_valid = loop_en ? tx_beat_valid : d_valid;
  assign rx_sof        = loop_en ? tx_sof        : d_sof;

  flit_lane_serdes u_flit_lane_serdes (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_quad_en(cfg_quad_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit), .tx_lanes(tx_lanes),
    .tx_beat_valid(tx_beat_valid), .tx_sof(tx_sof), .rx_cfg_width(rx_cfg_width),
    .rx_cfg_quad_en(rx_cfg_quad_en), .rx_lanes(rx_lanes), .rx_beat_valid(rx_beat_valid),
    .rx_sof(rx_sof), .rx_frame_reset(d_freset), .rx_flit_valid(rx_flit_valid),
    .rx_flit(rx_flit), .rx_frame_err(rx_frame_err)
  );

  int n_checks = 0;
  int n_fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int beats_of(input logic [1:0] w);
    return (w == 2'b00) ? 4 : (w == 2'b01) ? 8 : 16;
  endfunction

  // Lane image of beat b computed from the lane-packing rules.
  function automatic logic [LN-1:0] lanes_of(input logic [FW-1:0] f, input int b,
                                             input logic [1:0] w, input logic [NQ-1:0] m);
    logic [LN-1:0] l;
    logic [FW-1:0] s;
    int k, r;
    k = (w == 2'b00) ? 4 : (w == 2'b01) ? 2 : 1;
    s = f >> (b * k * QL);
    l = '0;
    r = 0;
    for (int q = 0; q < NQ; q++) begin
      if ((w == 2'b00 || m[q]) && r < k) begin
        l[q*QL +: QL] = s[r*QL +: QL];
        r++;
      end
    end
    return l;
  endfunction

  logic [FW-1:0] q_flit[$];
  logic [1:0]    q_w[$];
  logic [NQ-1:0] q_m[$];
  logic [FW-1:0] rx_exp[$];
  int            flits_sent = 0;
  int            flits_seen = 0;

  logic [FW-1:0] cur_f = '0;
  logic [1:0]    cur_w = '0;
  logic [NQ-1:0] cur_m = '0;
  int            cur_b = 0;
  bit            have_cur = 1'b0;

  // Transmit beat monitor (R2, R3, R4, R5, R6, R7) and receive config feed (R9).
  always @(negedge clk) begin
    if (rst_n && loop_en && tx_beat_valid) begin
      if (tx_sof) begin
        if (have_cur)
          check(cur_b == beats_of(cur_w), "R7", "beats per flit", FW'(cur_b), FW'(beats_of(cur_w)));
        if (q_flit.size() == 0) begin
          check(1'b0, "R1", "beat with no accepted flit", '0, '0);
        end else begin
          cur_f = q_flit.pop_front();
          cur_w = q_w.pop_front();
          cur_m = q_m.pop_front();
          cur_b = 0;
          have_cur = 1'b1;
          rx_cfg_width   = cur_w;
          rx_cfg_quad_en = cur_m;
          rx_exp.push_back(cur_f);
        end
      end
      check(tx_lanes == lanes_of(cur_f, cur_b, cur_w, cur_m),
            (cur_w == 2'b00) ? "R2" : (cur_w == 2'b01) ? "R3" : "R4",
            "lane image with R5 zero lanes and R6 held config",
            FW'(tx_lanes), FW'(lanes_of(cur_f, cur_b, cur_w, cur_m)));
      cur_b++;
    end
  end

  // Receive monitor (R8, R9, R10).
  always @(negedge clk) begin
    if (rst_n && rx_flit_valid) begin
      flits_seen++;
      if (rx_exp.size() == 0) begin
        check(1'b0, "R10", "unexpected rebuilt flit", rx_flit, '0);
      end else begin
        logic [FW-1:0] e;
        e = rx_exp.pop_front();
        check(rx_flit == e, "R8", "rebuilt flit (R9 unpacking)", rx_flit, e);
      end
    end
  end

  task automatic send(input logic [FW-1:0] f, input logic [1:0] w, input logic [NQ-1:0] m);
    tx_flit = f;
    cfg_width = w;
    cfg_quad_en = m;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    q_flit.push_back(f);
    q_w.push_back(w);
    q_m.push_back(m);
    flits_sent++;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drv(input bit v, input bit s, input bit fr, input logic [LN-1:0] l);
    d_valid = v;
    d_sof = s;
    d_freset = fr;
    d_lanes = l;
    @(negedge clk);
  endtask

  function automatic logic [FW-1:0] pattern(input int seed);
    logic [31:0] a, b;
    a = 32'(seed) * 32'h9E3779B1;
    b = 32'(seed) ^ 32'hC3A5_5A3C;
    return {16'(seed * 7 + 3), a, b};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(tx_ready == 1'b1, "R11", "tx_ready after reset", FW'(tx_ready), FW'(1));
    check(tx_beat_valid == 1'b0, "R11", "tx_beat_valid after reset", FW'(tx_beat_valid), '0);
    check(tx_lanes == '0, "R11", "tx_lanes after reset", FW'(tx_lanes), '0);
    check(rx_flit_valid == 1'b0, "R11", "rx_flit_valid after reset", FW'(rx_flit_valid), '0);
    check(rx_frame_err == 1'b0, "R11", "rx_frame_err after reset", FW'(rx_frame_err), '0);

    // R1 back-pressure while a flit is in flight
    send(pattern(seed), 2'b00, 4'h0);
    seed++;
    check(tx_ready == 1'b0, "R1", "tx_ready low mid-flit", FW'(tx_ready), '0);

    // Sweep of widths and usable masks; each pair back to back (R7),
    // with the next config applied while the previous flit is in flight (R6).
    for (int w = 0; w < 3; w++) begin
      for (int m = 0; m < 16; m++) begin
        int need;
        need = (w == 0) ? 0 : (w == 1) ? 2 : 1;
        if (w == 0 && m != 0 && m != 5) continue;
        if ($countones(4'(m)) < need) continue;
        send(pattern(seed), 2'(w), 4'(m));
        seed++;
        send(pattern(seed), 2'(w), 4'(m));
        seed++;
      end
    end
    // Config flipped right after acceptance must not affect the flit (R6)
    send(pattern(seed), 2'b00, 4'hF);
    cfg_width = 2'b10;
    cfg_quad_en = 4'h8;
    repeat (30) @(negedge clk);
    check(cur_b == beats_of(cur_w), "R7", "beats of final flit", FW'(cur_b), FW'(beats_of(cur_w)));
    check(flits_seen == flits_sent, "R8", "flits rebuilt", FW'(flits_seen), FW'(flits_sent));
    check(rx_exp.size() == 0, "R8", "pending rebuilt flits", FW'(rx_exp.size()), '0);

    // Framing error handling (R10)
    loop_en = 1'b0;
    rx_cfg_width = 2'b00;
    rx_cfg_quad_en = 4'h0;
    drv(1, 1, 0, 20'h11111);
    drv(1, 0, 0, 20'h22222);
    drv(1, 1, 0, 20'h33333);
    check(rx_frame_err == 1'b1, "R10", "sof mid-flit sets error", FW'(rx_frame_err), FW'(1));
    drv(1, 0, 0, 20'h44444);
    drv(1, 0, 0, 20'h55555);
    drv(1, 0, 0, 20'h66666);
    check(rx_frame_err == 1'b1, "R10", "error held while beats ignored", FW'(rx_frame_err), FW'(1));
    rx_exp.push_back({20'h55AA5, 20'h0F0F0, 20'hABCDE, 20'h12345});
    drv(1, 1, 1, 20'h12345);
    check(rx_frame_err == 1'b0, "R10", "reset with sof clears error", FW'(rx_frame_err), '0);
    drv(1, 0, 0, 20'hABCDE);
    drv(1, 0, 0, 20'h0F0F0);
    drv(1, 0, 0, 20'h55AA5);
    check(rx_flit_valid == 1'b1, "R8", "flit pulse after frame reset", FW'(rx_flit_valid), FW'(1));
    drv(0, 0, 0, 20'h0);
    check(rx_exp.size() == 0, "R10", "flit started with reset delivered", FW'(rx_exp.size()), '0);
    drv(1, 0, 0, 20'h77777);
    check(rx_frame_err == 1'b1, "R10", "beat without sof when idle", FW'(rx_frame_err), FW'(1));
    drv(0, 0, 1, 20'h0);
    check(rx_frame_err == 1'b0, "R10", "frame reset alone clears error", FW'(rx_frame_err), '0);
    drv(0, 0, 0, 20'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule